// File: doc/BRIEF.md
# Justification Control Overhead Channel

This block owns the justification control bits of a four-tributary time-division multiplexed frame. The frame is 1536 bits long and is cut into four sets of 384 bits. One bit moves per clock cycle, and frames repeat at 22375 per second on the line. A free-running frame position counter is shared by the transmit and receive halves.

On transmit, the block samples a stuff request per tributary at the start of each frame. It then writes three control nibbles into the overhead, at the head of the second, third and fourth sets. Each nibble holds one bit per tributary. When the user channel is on, the first nibble carries 4 bits of user data instead of the stuff requests. This yields an overhead data path of about 90 kbit/s.

On receive, the block collects the three nibbles. For each tributary it decides on stuffing by a two-of-three vote, so a single bad nibble (including the one taken over by user data) cannot change the decision. It then flags the tributary's justification-opportunity bit in the fourth set for removal when the vote says stuff. When the user channel is on, it also hands out the raw first nibble with a one-cycle strobe. The deassertion of `rst_n` is expected to be synchronous to `clk`.

Top module: `jc_overhead_chan`

## Requirements
- R1: Frame bits are numbered 0 to 1535, one per clock cycle, and the count restarts at 0 after 1535. `frame_start_o` is high exactly while the position is bit 0, which includes the first cycle after reset release.
- R2: `tx_oh_valid_o` is high exactly at frame bits 384k to 384k+3 for k = 1, 2, 3, which gives 12 cycles per frame. Within nibble k, bit 384k+J-1 belongs to tributary J (J = 1..4, input bit J-1). `tx_oh_bit_o` is 0 whenever `tx_oh_valid_o` is low.
- R3: `stuff_req_i`, `remote_tx_i` and `remote_en_i` are sampled only in the `frame_start_o` cycle. Changes at other times have no effect on the frame in progress.
- R4: With the user channel off (sampled `remote_en_i` = 0), all three nibbles carry the sampled stuff requests unchanged.
- R5: With the user channel on, nibble 1 (bits 384..387) carries the sampled `remote_tx_i`, with bit J-1 at bit 383+J. Nibbles 2 and 3 carry the stuff requests.
- R6: `rx_stuff_o[J-1]` becomes the majority of the three bits received at tributary J's positions in nibbles 1 to 3. It changes only at frame bit 1156 (the cycle after the last control bit) and holds otherwise, so one corrupted nibble leaves the decision unchanged.
- R7: `rx_drop_o` is high at frame bit 1155+J exactly when `rx_stuff_o[J-1]` is 1, and it is low at every other frame position.
- R8: With the user channel on, `rx_remote_o` takes the raw received nibble 1 at frame bit 1156, and `rx_remote_vld_o` is high for that one cycle. With it off, no strobe occurs and `rx_remote_o` keeps its value.
- R9: While `rst_n` is low, all outputs are 0 except `frame_start_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one frame bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| stuff_req_i | input | 4 | Per-tributary stuff request, bit J-1 for tributary J |
| remote_en_i | input | 1 | User channel enable, sampled at frame start |
| remote_tx_i | input | 4 | User nibble to send in control nibble 1 |
| rx_bit_i | input | 1 | Received frame bit at the current position |
| frame_start_o | output | 1 | High at frame bit 0 |
| tx_oh_valid_o | output | 1 | Current position is a control bit |
| tx_oh_bit_o | output | 1 | Control bit value to transmit |
| rx_stuff_o | output | 4 | Voted stuff decision per tributary |
| rx_drop_o | output | 1 | Current bit is a stuff bit to be discarded |
| rx_remote_o | output | 4 | Last received user nibble |
| rx_remote_vld_o | output | 1 | One-cycle strobe for a new user nibble |

## Verification
The embedded properties watch the position counter stepping and wrapping on every cycle. They also check that the sampled transmit settings stay frozen between frame starts, that the vote and user nibble outputs move only on the cycle after the last control bit, that the user strobe never lasts two cycles, and that a drop marker never coincides with a control bit or frame start. Only the bench scenarios can show the bit-to-tributary ordering of the nibbles, the substitution of user data into nibble 1, and the vote outcome under corruption of one or two nibbles. The same applies to the exact cycle of the drop markers and to the holding of the user nibble when the channel is off, all observed through a transmit-to-receive loopback with injected bit flips.

// File: rtl/jc_pkg.sv
package jc_pkg;

  // Classification of the current frame position
  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_CJ   = 2'd1,
    SLOT_JOPP = 2'd2
  } slot_e;

endpackage

// File: rtl/jc_frame_timer.sv
module jc_frame_timer
  import jc_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int NUM_SETS   = 4,
  parameter int NUM_TRIB   = 4,
  parameter int NUM_CJ     = 3,
  parameter int SET_BITS   = FRAME_BITS / NUM_SETS,
  parameter int SET_W      = $clog2(NUM_SETS),
  parameter int OFF_W      = $clog2(SET_BITS),
  parameter int TRIB_W     = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1,
  parameter int CJ_W       = (NUM_CJ > 1) ? $clog2(NUM_CJ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              frame_start_o,
  output slot_e             slot_o,
  output logic [CJ_W-1:0]   cj_idx_o,
  output logic [TRIB_W-1:0] bit_idx_o,
  output logic              last_cj_o
);

  localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_W'(SET_BITS - 1);
  localparam logic [OFF_W-1:0]  OFF_TRIB  = OFF_W'(NUM_TRIB);
  localparam logic [OFF_W-1:0]  OFF_JEND  = OFF_W'(2 * NUM_TRIB);
  localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(NUM_SETS - 1);
  localparam logic [SET_W-1:0]  SET_CJ0   = SET_W'(NUM_SETS - NUM_CJ);
  localparam logic [CJ_W-1:0]   CJ_LAST   = CJ_W'(NUM_CJ - 1);
  localparam logic [TRIB_W-1:0] TRIB_LAST = TRIB_W'(NUM_TRIB - 1);

  logic [SET_W-1:0] set_q, set_d;
  logic [OFF_W-1:0] off_q, off_d;

  // next position
  always_comb begin
    off_d = off_q + 1'b1;
    set_d = set_q;
    if (off_q == OFF_LAST) begin
      off_d = '0;
      set_d = (set_q == SET_LAST) ? '0 : set_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      off_q <= '0;
    end else begin
      set_q <= set_d;
      off_q <= off_d;
    end
  end

  // position decode
  always_comb begin
    slot_o    = SLOT_DATA;
    cj_idx_o  = '0;
    bit_idx_o = '0;
    if (set_q >= SET_CJ0 && off_q < OFF_TRIB) begin
      slot_o    = SLOT_CJ;
      cj_idx_o  = CJ_W'(set_q - SET_CJ0);
      bit_idx_o = TRIB_W'(off_q);
    end else if (set_q == SET_LAST && off_q >= OFF_TRIB && off_q < OFF_JEND) begin
      slot_o    = SLOT_JOPP;
      bit_idx_o = TRIB_W'(off_q - OFF_TRIB);
    end
  end

  assign frame_start_o = (set_q == '0) && (off_q == '0);
  assign last_cj_o     = (slot_o == SLOT_CJ) && (cj_idx_o == CJ_LAST) &&
                         (bit_idx_o == TRIB_LAST);

  // R1: the offset advances by one inside a set, the set index stays
  a_r1_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != OFF_LAST) |=> (off_q == $past(off_q) + 1'b1) && $stable(set_q));

  // R1: the last bit of the last set is followed by frame start
  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q == SET_LAST && off_q == OFF_LAST) |=> frame_start_o);

endmodule

// File: rtl/jc_tx_nibble.sv
module jc_tx_nibble
  import jc_pkg::*;
#(
  parameter int NUM_TRIB = 4,
  parameter int TRIB_W   = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1,
  parameter int CJ_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  slot_e               slot_i,
  input  logic [CJ_W-1:0]     cj_idx_i,
  input  logic [TRIB_W-1:0]   bit_idx_i,
  input  logic [NUM_TRIB-1:0] stuff_req_i,
  input  logic                remote_en_i,
  input  logic [NUM_TRIB-1:0] remote_tx_i,
  output logic                remote_en_q_o,
  output logic                oh_valid_o,
  output logic                oh_bit_o
);

  logic [NUM_TRIB-1:0] req_q, req_d;
  logic [NUM_TRIB-1:0] usr_q, usr_d;
  logic                en_q, en_d;

  // frame-start sampling
  always_comb begin
    req_d = req_q;
    usr_d = usr_q;
    en_d  = en_q;
    if (frame_start_i) begin
      req_d = stuff_req_i;
      usr_d = remote_tx_i;
      en_d  = remote_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      usr_q <= '0;
      en_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      usr_q <= usr_d;
      en_q  <= en_d;
    end
  end

  // nibble content: first nibble may carry user data
  always_comb begin
    oh_valid_o = (slot_i == SLOT_CJ);
    oh_bit_o   = 1'b0;
    if (oh_valid_o) begin
      if (cj_idx_i == '0 && en_q) oh_bit_o = usr_q[bit_idx_i];
      else                        oh_bit_o = req_q[bit_idx_i];
    end
  end

  assign remote_en_q_o = en_q;

  // R3: sampled settings stay frozen between frame starts
  a_r3_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(req_q) && $stable(usr_q) && $stable(en_q));

endmodule

// File: rtl/jc_rx_vote.sv
module jc_rx_vote
  import jc_pkg::*;
#(
  parameter int NUM_TRIB = 4,
  parameter int NUM_CJ   = 3,
  parameter int TRIB_W   = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1,
  parameter int CJ_W     = (NUM_CJ > 1) ? $clog2(NUM_CJ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  slot_e               slot_i,
  input  logic [CJ_W-1:0]     cj_idx_i,
  input  logic [TRIB_W-1:0]   bit_idx_i,
  input  logic                last_cj_i,
  input  logic                remote_en_i,
  input  logic                rx_bit_i,
  output logic [NUM_TRIB-1:0] stuff_o,
  output logic                drop_o,
  output logic [NUM_TRIB-1:0] remote_o,
  output logic                remote_vld_o
);

  logic [NUM_CJ-1:0][NUM_TRIB-1:0] cj_q, cj_d;
  logic [NUM_TRIB-1:0]             vote;
  logic [NUM_TRIB-1:0]             stuff_q, stuff_d;
  logic [NUM_TRIB-1:0]             rem_q, rem_d;
  logic                            vld_q, vld_d;

  // nibble capture, including the bit arriving this cycle
  always_comb begin
    cj_d = cj_q;
    if (slot_i == SLOT_CJ) cj_d[cj_idx_i][bit_idx_i] = rx_bit_i;
  end

  // per-tributary majority
  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_vote
    always_comb begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < NUM_CJ; k++) cnt = cnt + int'(cj_d[k][t]);
      vote[t] = (cnt > NUM_CJ / 2);
    end
  end

  always_comb begin
    stuff_d = last_cj_i ? vote : stuff_q;
    rem_d   = (last_cj_i && remote_en_i) ? cj_d[0] : rem_q;
    vld_d   = last_cj_i && remote_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cj_q    <= '0;
      stuff_q <= '0;
      rem_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      cj_q    <= cj_d;
      stuff_q <= stuff_d;
      rem_q   <= rem_d;
      vld_q   <= vld_d;
    end
  end

  assign stuff_o      = stuff_q;
  assign remote_o     = rem_q;
  assign remote_vld_o = vld_q;
  assign drop_o       = (slot_i == SLOT_JOPP) && stuff_q[bit_idx_i];

  // R6: decision moves only after the last control bit
  a_r6_vote_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !last_cj_i |=> $stable(stuff_q));

  // R8: user nibble moves only after the last control bit
  a_r8_remote_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !last_cj_i |=> $stable(rem_q));

  // R8: the strobe lasts a single cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/jc_overhead_chan.sv
module jc_overhead_chan
  import jc_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int NUM_SETS   = 4,
  parameter int NUM_TRIB   = 4,
  parameter int NUM_CJ     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIB-1:0] stuff_req_i,
  input  logic                remote_en_i,
  input  logic [NUM_TRIB-1:0] remote_tx_i,
  input  logic                rx_bit_i,
  output logic                frame_start_o,
  output logic                tx_oh_valid_o,
  output logic                tx_oh_bit_o,
  output logic [NUM_TRIB-1:0] rx_stuff_o,
  output logic                rx_drop_o,
  output logic [NUM_TRIB-1:0] rx_remote_o,
  output logic                rx_remote_vld_o
);

  localparam int TRIB_W = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1;
  localparam int CJ_W   = (NUM_CJ > 1) ? $clog2(NUM_CJ) : 1;

  slot_e             slot;
  logic [CJ_W-1:0]   cj_idx;
  logic [TRIB_W-1:0] bit_idx;
  logic              last_cj;
  logic              en_q;

  jc_frame_timer #(
    .FRAME_BITS (FRAME_BITS),
    .NUM_SETS   (NUM_SETS),
    .NUM_TRIB   (NUM_TRIB),
    .NUM_CJ     (NUM_CJ),
    .TRIB_W     (TRIB_W),
    .CJ_W       (CJ_W)
  ) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_o (frame_start_o),
    .slot_o        (slot),
    .cj_idx_o      (cj_idx),
    .bit_idx_o     (bit_idx),
    .last_cj_o     (last_cj)
  );

  jc_tx_nibble #(
    .NUM_TRIB (NUM_TRIB),
    .TRIB_W   (TRIB_W),
    .CJ_W     (CJ_W)
  ) u_tx (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_o),
    .slot_i        (slot),
    .cj_idx_i      (cj_idx),
    .bit_idx_i     (bit_idx),
    .stuff_req_i   (stuff_req_i),
    .remote_en_i   (remote_en_i),
    .remote_tx_i   (remote_tx_i),
    .remote_en_q_o (en_q),
    .oh_valid_o    (tx_oh_valid_o),
    .oh_bit_o      (tx_oh_bit_o)
  );

  jc_rx_vote #(
    .NUM_TRIB (NUM_TRIB),
    .NUM_CJ   (NUM_CJ),
    .TRIB_W   (TRIB_W),
    .CJ_W     (CJ_W)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot),
    .cj_idx_i     (cj_idx),
    .bit_idx_i    (bit_idx),
    .last_cj_i    (last_cj),
    .remote_en_i  (en_q),
    .rx_bit_i     (rx_bit_i),
    .stuff_o      (rx_stuff_o),
    .drop_o       (rx_drop_o),
    .remote_o     (rx_remote_o),
    .remote_vld_o (rx_remote_vld_o)
  );

  // R7: a drop marker never lands on a control bit or frame start
  a_r7_drop_placement: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop_o |-> !tx_oh_valid_o && !frame_start_o);

endmodule

// File: tb/tb_jc_overhead_chan.sv
module tb_jc_overhead_chan;

  localparam int FRAME = 1536;
  localparam int SETB  = 384;
  localparam int UPD   = 1156;

  logic       clk;
  logic       rst_n;
  logic [3:0] stuff_req;
  logic       remote_en;
  logic [3:0] remote_tx;
  logic       rx_bit;
  logic       frame_start;
  logic       tx_oh_valid;
  logic       tx_oh_bit;
  logic [3:0] rx_stuff;
  logic       rx_drop;
  logic [3:0] rx_remote;
  logic       rx_remote_vld;

  int         checks;
  int         errors;
  int         pos;
  logic [2:0] fmask;
  logic       flip;
  logic [3:0] prev_vote;
  logic [3:0] prev_rem;

  jc_overhead_chan dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .stuff_req_i     (stuff_req),
    .remote_en_i     (remote_en),
    .remote_tx_i     (remote_tx),
    .rx_bit_i        (rx_bit),
    .frame_start_o   (frame_start),
    .tx_oh_valid_o   (tx_oh_valid),
    .tx_oh_bit_o     (tx_oh_bit),
    .rx_stuff_o      (rx_stuff),
    .rx_drop_o       (rx_drop),
    .rx_remote_o     (rx_remote),
    .rx_remote_vld_o (rx_remote_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench's own frame position
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= 0;
    else        pos <= (pos + 1) % FRAME;
  end

  // loopback with selectable nibble corruption
  always_comb begin
    int s;
    int o;
    s = pos / SETB;
    o = pos % SETB;
    flip = (s >= 1) && (o < 4) && fmask[s-1];
  end
  assign rx_bit = tx_oh_bit ^ flip;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic goto_frame_start();
    while (pos != 0) @(negedge clk);
  endtask

  // One frame with loopback; checks every position of it
  task automatic run_frame(input logic [3:0] req, input logic [3:0] usr,
                           input logic en, input logic [2:0] fm, input logic chg);
    logic [3:0] n1, n2, n3, vote, exp_rem;
    int tx_err, fs_err, drop_err, vld_err, hold_err;
    tx_err = 0; fs_err = 0; drop_err = 0; vld_err = 0; hold_err = 0;
    goto_frame_start();
    stuff_req = req;
    remote_tx = usr;
    remote_en = en;
    fmask     = fm;
    n1 = (en ? usr : req) ^ {4{fm[0]}};
    n2 = req ^ {4{fm[1]}};
    n3 = req ^ {4{fm[2]}};
    vote    = (n1 & n2) | (n1 & n3) | (n2 & n3);
    exp_rem = en ? n1 : prev_rem;
    for (int p = 0; p < FRAME; p++) begin
      int s;
      int o;
      logic ev, eb, ed;
      s  = p / SETB;
      o  = p % SETB;
      ev = (s >= 1) && (o < 4);
      eb = ev ? ((s == 1 && en) ? usr[o] : req[o]) : 1'b0;
      ed = (p >= UPD && p < UPD + 4) ? vote[p-UPD] : 1'b0;
      if (tx_oh_valid !== ev || tx_oh_bit !== eb) tx_err++;
      if (frame_start !== (p == 0)) fs_err++;
      if (rx_drop !== ed) drop_err++;
      if (rx_remote_vld !== (p == UPD && en)) vld_err++;
      if (p < UPD && (rx_stuff !== prev_vote || rx_remote !== prev_rem)) hold_err++;
      if (p >= UPD && (rx_stuff !== vote || rx_remote !== exp_rem)) hold_err++;
      if (p == UPD) begin
        chk("R6 voted stuff decision", 32'(rx_stuff), 32'(vote));
        chk("R8 received user nibble", 32'(rx_remote), 32'(exp_rem));
      end
      if (chg && p == 10) begin
        stuff_req = ~req;
        remote_tx = ~usr;
        remote_en = ~en;
      end
      @(negedge clk);
    end
    if (chg)     chk("R3 mid-frame input change ignored, nibble mismatches", 32'(tx_err), 0);
    else if (en) chk("R5 user nibble then stuff nibbles, mismatches", 32'(tx_err), 0);
    else         chk("R4 three stuff nibbles, mismatches", 32'(tx_err), 0);
    chk("R1 R2 frame start placement, mismatches", 32'(fs_err), 0);
    chk("R7 drop marker positions, mismatches", 32'(drop_err), 0);
    chk("R8 user strobe positions, mismatches", 32'(vld_err), 0);
    chk("R6 decision hold and update timing, mismatches", 32'(hold_err), 0);
    prev_vote = vote;
    prev_rem  = exp_rem;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    stuff_req = '0; remote_en = 1'b0; remote_tx = '0; fmask = '0;
    repeat (3) @(negedge clk);
    chk("R9 frame_start_o in reset", 32'(frame_start), 1);
    chk("R9 tx outputs in reset", {30'd0, tx_oh_valid, tx_oh_bit}, 0);
    chk("R9 rx outputs in reset", {22'd0, rx_stuff, rx_drop, rx_remote, rx_remote_vld}, 0);
    rst_n = 1'b1;
    prev_vote = '0;
    prev_rem  = '0;
  endtask

  task automatic t_remote_off();        run_frame(4'b1010, 4'b0000, 1'b0, 3'b000, 1'b0); endtask
  task automatic t_remote_on();         run_frame(4'b0011, 4'b0110, 1'b1, 3'b000, 1'b0); endtask
  task automatic t_mid_frame_change();  run_frame(4'b0101, 4'b1111, 1'b0, 3'b010, 1'b1); endtask
  task automatic t_user_nibble_flip();  run_frame(4'b1100, 4'b1001, 1'b1, 3'b001, 1'b0); endtask
  task automatic t_two_nibbles_bad();   run_frame(4'b0110, 4'b0000, 1'b0, 3'b110, 1'b0); endtask
  task automatic t_remote_hold();       run_frame(4'b1111, 4'b0101, 1'b0, 3'b100, 1'b0); endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_remote_off();
    t_remote_on();
    t_mid_frame_change();
    t_user_nibble_flip();
    t_two_nibbles_bad();
    t_remote_hold();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule